// File: doc/BRIEF.md
# Integer Arithmetic and Shift Unit

This block carries out integer data-processing instructions against a file of sixteen 64-bit registers. A single 32-bit instruction word, qualified by a valid strobe, is decoded, its operands are read combinationally, the result is computed in the same cycle and written back at the next rising clock edge. The operations are add, subtract, negate, absolute value, multiply, multiply-accumulate, multiply-subtract and shifts by an immediate. Each one works either on the low 32 bits of its registers or on the full 64 bits.

A 32-bit operation replaces only the low half of its destination and leaves the high half as it was. Shift amounts are a 7-bit two's-complement immediate whose sign picks the direction. A neighbouring transfer path fills and reads the register file through a host port. Encodings that the unit does not execute raise an illegal flag and write nothing.

Top module: `ialu_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears all sixteen registers to zero. While instr_valid is low, wr_en and illegal are low.
- R2: When host_we is high and instr_valid is low, host_wdata is written to register host_widx at the rising edge. When instr_valid is high, the host write is dropped. host_rdata always shows register host_ridx combinationally.
- R3: The instruction fields are: group = instr[21:20], sub-opcode = instr[7:5], destination = instr[15:12], first source = instr[19:16], second source = instr[3:0]. All other instruction bits have no effect.
- R4: Group 3 with an odd sub-opcode is a 64-bit operation: 1 = absolute value, 3 = negate, 5 = add, 7 = subtract (first minus second). The result wraps modulo 2^64, and the absolute value of the most negative number is that same number.
- R5: Group 3 with an even sub-opcode is a 32-bit operation on the low halves: 0 = absolute value, 2 = negate, 4 = add, 6 = subtract. The 32-bit result, wrapped modulo 2^32, replaces bits 31:0 of the destination, and bits 63:32 keep their old value.
- R6: In group 1, the sub-opcodes are: 0 = low 32 bits of the 32-bit product, 1 = low 64 bits of the 64-bit product, 2 = destination low half plus the 32-bit product, 3 = destination low half minus the 32-bit product. Sub-opcodes 0, 2 and 3 follow the half-register rule of R5.
- R7: The shift amount is the signed 7-bit value {instr[7:5], instr[3:0]}. Group 0 shifts the low 32 bits of the first source (half-register rule of R5), and group 2 shifts all 64 bits. A non-negative amount shifts left, giving zero once the amount reaches the width. A negative amount shifts right arithmetically by its magnitude, filling every bit with the sign once the magnitude reaches the width.
- R8: Group 1 with a sub-opcode of 4 to 7 drives illegal high and wr_en low, and no register changes.
- R9: For a valid legal instruction, wr_en is high, wr_idx is the destination and wr_data is the full 64-bit value being written, all in the same cycle. The register holds that value from the next edge, so a following instruction reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| host_we | input | 1 | Host write strobe into the register file |
| host_widx | input | 4 | Host write register index |
| host_wdata | input | 64 | Host write data |
| host_ridx | input | 4 | Host read register index |
| host_rdata | output | 64 | Contents of register host_ridx |
| illegal | output | 1 | Current instruction is not executable |
| wr_en | output | 1 | A result is written at the next edge |
| wr_idx | output | 4 | Destination register of the result |
| wr_data | output | 64 | Full 64-bit value being written |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- Shift immediates at their extremes (+63, -1, -64 and a magnitude of 32 on the half-width shift). A decoder that drops the sign extension or concatenates the two fields in the wrong order shifts the wrong way or by the wrong distance.
- The absolute value of the most negative 32-bit and 64-bit numbers. A saturating implementation would produce the largest positive value instead of the same number.
- Half-width results with a distinctive pattern in the destination's upper half. A design that zeroes or sign-extends the upper half, instead of keeping it, is caught here.
- Multiply-accumulate and multiply-subtract using the destination as an addend. Reading the wrong port here gives a wrong low half.
- Host writes issued under a valid instruction, which must be dropped.
- The illegal group 1 codes, which must leave every register untouched.

// File: rtl/ialu_pkg.sv
// Package ialu_pkg
// Shared sizes, field decode types and group codes for the integer unit.
// Assumes the 32-bit instruction layout with 4-bit register indices.
package ialu_pkg;
    localparam int XLEN  = 64;
    localparam int HLEN  = XLEN / 2;
    localparam int NREG  = 16;
    localparam int RIDX  = $clog2(NREG);
    localparam int ILEN  = 32;
    localparam int SHW   = 7;

    typedef enum logic [1:0] {
        GRP_SHIFT_HALF = 2'd0,
        GRP_MULTIPLY   = 2'd1,
        GRP_SHIFT_FULL = 2'd2,
        GRP_ARITH      = 2'd3
    } grp_e;

    typedef struct packed {
        logic                  go;
        grp_e                  grp;
        logic [2:0]            sub;
        logic [RIDX-1:0]       rd;
        logic [RIDX-1:0]       rs1;
        logic [RIDX-1:0]       rs2;
        logic signed [SHW-1:0] shamt;
    } dec_t;
endpackage

// File: rtl/ialu_regfile.sv
// Module ialu_regfile
// Register file with NRD combinational read ports and one synchronous write port.
// Assumes synchronous active-low reset clearing every entry.
module ialu_regfile #(
    parameter int NREG = 16,
    parameter int W    = 64,
    parameter int NRD  = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [W-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata
);
    logic [W-1:0] mem [NREG];

    // Purpose: clear on reset, otherwise store one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Purpose: combinational read of port p.
        always_comb rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/ialu_decode.sv
// Module ialu_decode
// Splits the instruction word into fields, builds the signed shift
// immediate and flags the group-1 codes that the unit does not execute.
// Assumes fields outside the decoded positions carry no meaning.
module ialu_decode
    import ialu_pkg::*;
(
    input  logic            valid,
    input  logic [ILEN-1:0] instr,
    output dec_t            dec,
    output logic            illegal
);
    logic bad_code;

    // Purpose: field extraction and shift immediate assembly.
    always_comb begin
        dec.grp   = grp_e'(instr[21:20]);
        dec.sub   = instr[7:5];
        dec.rd    = instr[15:12];
        dec.rs1   = instr[19:16];
        dec.rs2   = instr[3:0];
        dec.shamt = $signed({instr[7:5], instr[3:0]});
        bad_code  = (dec.grp == GRP_MULTIPLY) && instr[7];
        illegal   = valid && bad_code;
        dec.go    = valid && !bad_code;
    end
endmodule

// File: rtl/ialu_exec.sv
// Module ialu_exec
// Combinational datapath: computes the 64-bit write value from the decoded
// instruction, both sources and the old destination value.
// Assumes half-width results keep the destination's upper half.
module ialu_exec
    import ialu_pkg::*;
(
    input  dec_t            dec,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [XLEN-1:0] dst_old,
    output logic [XLEN-1:0] result
);
    logic [HLEN-1:0] lo_a, lo_b, lo_d, prod32, half_res, sh_half;
    logic [XLEN-1:0] full_res, sh_full;
    logic [SHW-1:0]  mag;
    logic            go_right, wide;

    // Purpose: shifter for both widths, direction from the immediate sign.
    always_comb begin
        lo_a     = src_a[HLEN-1:0];
        go_right = dec.shamt[SHW-1];
        mag      = ~dec.shamt + 7'd1;
        if (go_right) begin
            sh_half = $signed(lo_a)  >>> mag;
            sh_full = $signed(src_a) >>> mag;
        end else begin
            sh_half = lo_a  << dec.shamt[SHW-2:0];
            sh_full = src_a << dec.shamt[SHW-2:0];
        end
    end

    // Purpose: operation select and merge of half-width results.
    always_comb begin
        lo_b     = src_b[HLEN-1:0];
        lo_d     = dst_old[HLEN-1:0];
        prod32   = lo_a * lo_b;
        half_res = '0;
        full_res = '0;
        wide     = 1'b0;
        unique case (dec.grp)
            GRP_SHIFT_HALF: half_res = sh_half;
            GRP_SHIFT_FULL: begin full_res = sh_full; wide = 1'b1; end
            GRP_MULTIPLY: begin
                case (dec.sub)
                    3'd0: half_res = prod32;
                    3'd1: begin full_res = src_a * src_b; wide = 1'b1; end
                    3'd2: half_res = lo_d + prod32;
                    3'd3: half_res = lo_d - prod32;
                    default: half_res = lo_d;
                endcase
            end
            GRP_ARITH: begin
                wide = dec.sub[0];
                case (dec.sub[2:1])
                    2'd0: begin
                        half_res = lo_a[HLEN-1] ? -lo_a : lo_a;
                        full_res = src_a[XLEN-1] ? -src_a : src_a;
                    end
                    2'd1: begin half_res = -lo_a;        full_res = -src_a;        end
                    2'd2: begin half_res = lo_a + lo_b;  full_res = src_a + src_b; end
                    default: begin half_res = lo_a - lo_b; full_res = src_a - src_b; end
                endcase
            end
            default: half_res = lo_d;
        endcase
        result = wide ? full_res : {dst_old[XLEN-1:HLEN], half_res};
    end
endmodule

// File: rtl/ialu_unit.sv
// Module ialu_unit
// Top of the integer unit: decode, register file read, execute and write
// back in one cycle. The host port shares the write port and yields to
// any valid instruction.
// Assumes synchronous active-low reset.
module ialu_unit
    import ialu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [31:0]      instr,
    input  logic             host_we,
    input  logic [3:0]       host_widx,
    input  logic [63:0]      host_wdata,
    input  logic [3:0]       host_ridx,
    output logic [63:0]      host_rdata,
    output logic             illegal,
    output logic             wr_en,
    output logic [3:0]       wr_idx,
    output logic [63:0]      wr_data
);
    localparam int NRD = 4;

    dec_t                       dec;
    logic [NRD-1:0][RIDX-1:0]   raddr;
    logic [NRD-1:0][XLEN-1:0]   rdata;
    logic [XLEN-1:0]            rd_q;
    logic                       rf_we;
    logic [RIDX-1:0]            rf_waddr;
    logic [XLEN-1:0]            rf_wdata;

    ialu_decode u_dec (
        .valid   (instr_valid),
        .instr   (instr),
        .dec     (dec),
        .illegal (illegal)
    );

    // Purpose: read-port address map (0 src1, 1 src2, 2 dest, 3 host).
    always_comb begin
        raddr[0] = dec.rs1;
        raddr[1] = dec.rs2;
        raddr[2] = dec.rd;
        raddr[3] = host_ridx;
    end

    ialu_regfile #(.NREG(NREG), .W(XLEN), .NRD(NRD)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign rd_q       = rdata[2];
    assign host_rdata = rdata[3];

    ialu_exec u_exec (
        .dec     (dec),
        .src_a   (rdata[0]),
        .src_b   (rdata[1]),
        .dst_old (rd_q),
        .result  (wr_data)
    );

    // Purpose: write-port arbitration, instruction path before host path.
    always_comb begin
        wr_en    = dec.go;
        wr_idx   = dec.rd;
        rf_we    = dec.go || (host_we && !instr_valid);
        rf_waddr = instr_valid ? dec.rd : host_widx;
        rf_wdata = instr_valid ? wr_data : host_wdata;
    end
endmodule

// File: rtl/ialu_unit_chk.sv
// Module ialu_unit_chk
// Temporal checks on the integer unit, attached by bind.
// Assumes the same clock and synchronous active-low reset as the unit.
module ialu_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [31:0] instr,
    input logic        host_we,
    input logic [3:0]  host_widx,
    input logic [63:0] host_wdata,
    input logic [3:0]  host_ridx,
    input logic [63:0] host_rdata,
    input logic        illegal,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [63:0] wr_data,
    input logic [63:0] rd_q
);
    logic half_op;
    assign half_op = (instr[21:20] == 2'd0)
                  || (instr[21:20] == 2'd1 && instr[7:5] != 3'd1)
                  || (instr[21:20] == 2'd3 && !instr[5]);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (!wr_en && !illegal));

    // R8
    illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en);

    // R5
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && half_op) |-> (wr_data[63:32] == rd_q[63:32]));

    // R9
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && host_ridx == wr_idx) |=>
            (host_ridx != $past(host_ridx)) || (host_rdata == $past(wr_data)));

    // R2
    host_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !instr_valid && host_ridx == host_widx) |=>
            (host_ridx != $past(host_ridx)) || (host_rdata == $past(host_wdata)));
endmodule

bind ialu_unit ialu_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_valid(instr_valid),
    .instr      (instr),
    .host_we    (host_we),
    .host_widx  (host_widx),
    .host_wdata (host_wdata),
    .host_ridx  (host_ridx),
    .host_rdata (host_rdata),
    .illegal    (illegal),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_q       (rd_q)
);

// File: tb/ialu_unit_bench.sv
// Bench for ialu_unit: directed corners plus seeded random instructions,
// checked against a bench-side register model.
module ialu_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [31:0] instr;
    logic        host_we;
    logic [3:0]  host_widx;
    logic [63:0] host_wdata;
    logic [3:0]  host_ridx;
    logic [63:0] host_rdata;
    logic        illegal;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [63:0] wr_data;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    logic [63:0] m [16];

    always #5 clk = ~clk;

    ialu_unit u_ialu_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .host_we(host_we), .host_widx(host_widx), .host_wdata(host_wdata),
        .host_ridx(host_ridx), .host_rdata(host_rdata), .illegal(illegal),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] g, input logic [2:0] s,
                                       input logic [3:0] d, input logic [3:0] a,
                                       input logic [3:0] b);
        return {10'd0, g, a, d, 4'd0, s, 1'b0, b};
    endfunction

    function automatic logic [31:0] mksh(input logic [1:0] g, input logic [3:0] d,
                                         input logic [3:0] a, input int amt);
        logic [6:0] v = 7'(amt);
        return {10'd0, g, a, d, 4'd0, v[6:4], 1'b0, v[3:0]};
    endfunction

    function automatic bit legal(input logic [31:0] ins);
        return !(ins[21:20] == 2'd1 && ins[7:5] >= 3'd4);
    endfunction

    function automatic logic [63:0] calc(input logic [31:0] ins);
        logic [63:0] a, b, d, r64;
        logic [31:0] r32, p;
        bit wide;
        int sh, n;
        a = m[ins[19:16]]; b = m[ins[3:0]]; d = m[ins[15:12]];
        sh = int'({ins[7:5], ins[3:0]});
        if (sh >= 64) sh = sh - 128;
        p = a[31:0] * b[31:0];
        wide = 0; r32 = 0; r64 = 0;
        case (ins[21:20])
            2'd0: begin
                if (sh < 0) begin
                    n = -sh;
                    if (n >= 32) r32 = {32{a[31]}};
                    else r32 = 32'($signed(a[31:0]) >>> n);
                end else r32 = (sh >= 32) ? 32'd0 : a[31:0] << sh;
            end
            2'd2: begin
                wide = 1;
                if (sh < 0) begin
                    n = -sh;
                    if (n >= 64) r64 = {64{a[63]}};
                    else r64 = 64'($signed(a) >>> n);
                end else r64 = a << sh;
            end
            2'd1: case (ins[7:5])
                3'd0: r32 = p;
                3'd1: begin wide = 1; r64 = a * b; end
                3'd2: r32 = d[31:0] + p;
                default: r32 = d[31:0] - p;
            endcase
            default: case (ins[7:5])
                3'd0: r32 = a[31] ? 32'd0 - a[31:0] : a[31:0];
                3'd1: begin wide = 1; r64 = a[63] ? 64'd0 - a : a; end
                3'd2: r32 = 32'd0 - a[31:0];
                3'd3: begin wide = 1; r64 = 64'd0 - a; end
                3'd4: r32 = a[31:0] + b[31:0];
                3'd5: begin wide = 1; r64 = a + b; end
                3'd6: r32 = a[31:0] - b[31:0];
                default: begin wide = 1; r64 = a - b; end
            endcase
        endcase
        return wide ? r64 : {d[63:32], r32};
    endfunction

    function automatic string tag(input logic [31:0] ins);
        if (!legal(ins)) return "R8";
        case (ins[21:20])
            2'd0, 2'd2: return "R7";
            2'd1: return "R6";
            default: return ins[5] ? "R4" : "R5";
        endcase
    endfunction

    // one cycle: inputs driven after negedge, outputs checked mid-cycle
    task automatic step(input bit v, input logic [31:0] ins, input bit hw,
                        input logic [3:0] hwi, input logic [63:0] hwd, input string t);
        bit ok;
        logic [63:0] e;
        instr_valid = v; instr = ins; host_we = hw; host_widx = hwi; host_wdata = hwd;
        #2;
        ok = v && legal(ins);
        e = ok ? calc(ins) : 64'd0;
        if (v) begin
            chk({t, " illegal"}, {63'd0, illegal}, {63'd0, !ok});
            chk({t, " wr_en"}, {63'd0, wr_en}, {63'd0, ok});
            if (ok) begin
                chk({t, " R3 wr_idx"}, {60'd0, wr_idx}, {60'd0, ins[15:12]});
                chk({t, " R9 wr_data"}, wr_data, e);
            end
        end else begin
            chk("R1 idle wr_en", {63'd0, wr_en}, 64'd0);
        end
        chk("R2 host_rdata", host_rdata, m[host_ridx]);
        @(posedge clk);
        if (ok) m[ins[15:12]] = e;
        else if (hw && !v) m[hwi] = hwd;
        @(negedge clk);
    endtask

    task automatic load(input logic [3:0] i, input logic [63:0] val);
        step(0, 32'd0, 1, i, val, "R2");
    endtask

    task automatic exec(input logic [31:0] ins, input string t);
        step(1, ins, 0, 4'd0, 64'd0, t);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) m[i] = 64'd0;
        rst_n = 0; instr_valid = 0; instr = 0; host_we = 0;
        host_widx = 0; host_wdata = 0; host_ridx = 0;
        // dirty the file before reset so clearing is visible
        @(negedge clk);
        rst_n = 1;
        host_we = 1; host_widx = 4'd5; host_wdata = 64'hDEAD;
        @(negedge clk);
        host_we = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        // R1: every entry reads zero
        for (int i = 0; i < 16; i++) begin
            host_ridx = 4'(i);
            #1 chk("R1 reset value", host_rdata, 64'd0);
        end
        chk("R1 idle illegal", {63'd0, illegal}, 64'd0);

        // R2: host write, then host write under a valid instruction is dropped
        host_ridx = 4'd1;
        load(4'd1, 64'h1111_2222_3333_4444);
        load(4'd2, 64'h8000_0000_0000_0000);
        load(4'd3, 64'hABCD_0123_8000_0000);
        step(1, mk(2'd3, 3'd5, 4'd4, 4'd1, 4'd1), 1, 4'd1, 64'h55, "R2");
        #1 chk("R2 dropped host write", host_rdata, 64'h1111_2222_3333_4444);

        // R4: abs64 of most negative, neg64, sub64 wrap
        exec(mk(2'd3, 3'd1, 4'd6, 4'd2, 4'd0), "R4");
        exec(mk(2'd3, 3'd3, 4'd7, 4'd1, 4'd0), "R4");
        exec(mk(2'd3, 3'd7, 4'd8, 4'd0, 4'd1), "R4");
        // R5: abs32 of 0x80000000 keeps upper half of destination
        load(4'd9, 64'hFEED_FACE_0000_0001);
        exec(mk(2'd3, 3'd0, 4'd9, 4'd3, 4'd0), "R5");
        host_ridx = 4'd9;
        #1 chk("R5 upper kept", host_rdata, 64'hFEED_FACE_8000_0000);
        // R6: mac and msc against a loaded destination
        exec(mk(2'd1, 3'd2, 4'd9, 4'd1, 4'd1), "R6");
        exec(mk(2'd1, 3'd3, 4'd9, 4'd3, 4'd1), "R6");
        exec(mk(2'd1, 3'd1, 4'd10, 4'd1, 4'd3), "R6");
        // R7: shift extremes
        exec(mksh(2'd0, 4'd11, 4'd3, -1), "R7");
        exec(mksh(2'd0, 4'd11, 4'd3, -32), "R7");
        exec(mksh(2'd0, 4'd11, 4'd1, 63), "R7");
        exec(mksh(2'd0, 4'd11, 4'd1, 4), "R7");
        exec(mksh(2'd2, 4'd12, 4'd2, -64), "R7");
        exec(mksh(2'd2, 4'd12, 4'd1, 63), "R7");
        exec(mksh(2'd2, 4'd12, 4'd1, -5), "R7");
        exec(mksh(2'd2, 4'd12, 4'd1, 0), "R7");
        // R8: illegal codes leave the destination alone
        host_ridx = 4'd1;
        exec(mk(2'd1, 3'd4, 4'd1, 4'd2, 4'd2), "R8");
        exec(mk(2'd1, 3'd7, 4'd1, 4'd2, 4'd2), "R8");
        #1 chk("R8 no write", host_rdata, 64'h1111_2222_3333_4444);
        // R9: back-to-back dependence
        exec(mk(2'd3, 3'd5, 4'd13, 4'd1, 4'd1), "R9");
        exec(mk(2'd3, 3'd5, 4'd13, 4'd13, 4'd13), "R9");

        // random phase; R3 unused instruction bits are random
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ins;
            host_ridx = 4'($urandom);
            if ($urandom % 6 == 0) begin
                load(4'($urandom), {$urandom, $urandom});
            end else begin
                ins = $urandom;
                exec(ins, tag(ins));
            end
        end
        for (int i = 0; i < 16; i++) begin
            host_ridx = 4'(i);
            #1 chk("R3 final register", host_rdata, m[i]);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule